// File: doc/BRIEF.md
# E1 Receive Slot Timing Generator

This block runs on the recovered 2.048 MHz receive line clock, one payload bit per clock. It produces the timing strobes that terminal equipment needs to take in E1 receive payload. The block keeps a bit counter and a slot counter inside each 256-bit frame, and a frame counter inside each 16-frame multiframe. From these counters it derives four sets of outputs:

- a 5-bit number for the slot now being output;
- a per-slot strobe on the slot's last (least significant) bit;
- end-of-frame and end-of-multiframe sync pulses;
- a fractional payload path that serves only the slots chosen by a 32-bit mask.

Alignment comes from outside. A frame-start marker says that the next bit is bit 0 of slot 0. A multiframe-start marker does the same and also says that the next frame is frame 0. Until the first marker after reset, the counters hold at zero and every strobe stays low.

The slot strobe pin has two roles. When the fractional path is off, it is the per-slot strobe at 256 kHz. When the fractional path is on, it is one of two things, chosen by a style input:

- a gapped copy of the bit clock, present only during chosen slots (data is taken on its falling edge);
- a level enable that is high for whole bit periods of chosen slots, for use with the ungapped serial clock.

The sync pulses are driven only when the 2-bit slip selection asks for elastic-buffer bypass.

Top module: `e1_rx_slot_timer`

## Requirements
- R1: While `rst` is high, and after it until the first `frame_mark` or `mf_mark` is sampled, `ts_num` is 0 and `ts_clk`, `fsync`, `msync` and `frac_data` are low.
- R2: After a marker is sampled at a rising edge, the next cycle is bit 0 of slot 0. Bits then advance by one per clock, 8 per slot, MSB first. `ts_num` holds the slot index (0 to 31) and wraps from 31 to 0 after 256 bits.
- R3: With `frac_en` = 0, `ts_clk` is high for exactly one full cycle per slot, the cycle of bit index 7 (the LSB), and low in the other seven.
- R4: `fsync` is high for the single cycle of bit 7 of slot 31 (the last bit of a frame) when the slip selection is bypass.
- R5: `mf_mark` zeroes the frame count and starts a frame. Every other frame start (a `frame_mark` or the natural wrap after bit 255) advances the count modulo 16. `msync` is high only together with `fsync`, while the count is 15.
- R6: Bypass is `slip_mode` = 2'b00 or 2'b11. Then `sync_oe` = 1. For 2'b01 and 2'b10, `sync_oe` = 0 and `fsync` and `msync` stay low.
- R7: `frac_data` equals `rx_bit` delayed by one cycle when `frac_en` = 1 and `slot_mask[n]` is set for the current slot n. Otherwise it is 0.
- R8: With `frac_en` = 1 and `frac_style` = 0 (gapped clock), `ts_clk` follows `clk` (high in the high phase, low in the low phase) during chosen slots, and is low throughout unchosen slots.
- R9: With `frac_en` = 1 and `frac_style` = 1 (enable), `ts_clk` is held high over both clock phases of chosen slots and low in unchosen slots.
- R10: A `frame_mark` sampled in the middle of a frame realigns at once: the next cycle has `ts_num` = 0 at bit 0, and the frame count advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive line clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_mark | input | 1 | Next cycle is bit 0 of a frame |
| mf_mark | input | 1 | Next cycle is bit 0 of frame 0 of a multiframe |
| slip_mode | input | 2 | Slip buffer selection; 00 or 11 means bypass |
| frac_en | input | 1 | Fractional payload output on |
| frac_style | input | 1 | 0: gapped clock on `ts_clk`; 1: level enable on `ts_clk` |
| slot_mask | input | 32 | Bit n set: slot n belongs to the fractional payload |
| rx_bit | input | 1 | Receive payload bit of the current cycle |
| ts_clk | output | 1 | Slot strobe, gapped clock or fractional enable |
| ts_num | output | 5 | Number of the slot now being output |
| fsync | output | 1 | Last bit of frame pulse |
| msync | output | 1 | Last bit of multiframe pulse |
| sync_oe | output | 1 | Sync pins are driven (bypass) |
| frac_data | output | 1 | Fractional payload bit |

## Verification
Every counter-derived output (`ts_num`, the slot strobe, both syncs and `frac_data`) moves one rising edge after the marker or bit that causes it. `sync_oe` and the mode choice of `ts_clk` follow the configuration inputs within the same cycle. The bench changes inputs only at falling edges and updates its own position model at each rising edge. It compares every output 5 ns after the rising edge, and compares `ts_clk` again 5 ns after the falling edge. The second sample is what tells the gapped clock apart from the level enable.

// File: rtl/e1_rx_timing_pkg.sv
package e1_rx_timing_pkg;

    // Default frame geometry
    localparam int unsigned DEF_SLOTS      = 32;
    localparam int unsigned DEF_SLOT_BITS  = 8;
    localparam int unsigned DEF_MF_FRAMES  = 16;

    // How the shared slot strobe pin behaves when the fractional path is on
    typedef enum logic {
        FRAC_GAPPED_CLK  = 1'b0,
        FRAC_LEVEL_ENBL  = 1'b1
    } frac_style_e;

    // Decoded strobe set handed from the decoder to the output stage
    typedef struct packed {
        logic slot_lsb;
        logic frame_end;
        logic mf_end;
        logic slot_chosen;
        logic bypass;
    } strobe_set_t;

    // Slip selection: both-equal codes bypass the elastic store
    function automatic logic slip_is_bypass(input logic [1:0] sel);
        return (sel == 2'b00) || (sel == 2'b11);
    endfunction

endpackage

// File: rtl/e1_rx_pos_ctr.sv
module e1_rx_pos_ctr #(
    parameter int unsigned SLOTS     = 32,
    parameter int unsigned SLOT_BITS = 8,
    parameter int unsigned SLOT_W    = $clog2(SLOTS),
    parameter int unsigned BIT_W     = $clog2(SLOT_BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              running,
    output logic [BIT_W-1:0]  bit_idx,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              slot_last_bit,
    output logic              frame_last_bit
);

    localparam logic [BIT_W-1:0]  BIT_TOP  = BIT_W'(SLOT_BITS - 1);
    localparam logic [SLOT_W-1:0] SLOT_TOP = SLOT_W'(SLOTS - 1);

    logic [BIT_W-1:0]  bit_nxt;
    logic [SLOT_W-1:0] slot_nxt;

    assign slot_last_bit  = (bit_idx == BIT_TOP);
    assign frame_last_bit = slot_last_bit && (slot_idx == SLOT_TOP);

    // Bit increment: power-of-two slots wrap for free, others compare
    generate
        if ((1 << BIT_W) == SLOT_BITS) begin : g_bit_pow2
            assign bit_nxt = bit_idx + 1'b1;
        end else begin : g_bit_cmp
            assign bit_nxt = slot_last_bit ? '0 : bit_idx + 1'b1;
        end
        if ((1 << SLOT_W) == SLOTS) begin : g_slot_pow2
            assign slot_nxt = slot_idx + 1'b1;
        end else begin : g_slot_cmp
            assign slot_nxt = (slot_idx == SLOT_TOP) ? '0 : slot_idx + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            running  <= 1'b0;
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (start) begin
            running  <= 1'b1;
            bit_idx  <= '0;
            slot_idx <= '0;
        end else if (running) begin
            bit_idx <= bit_nxt;
            if (slot_last_bit) begin
                slot_idx <= slot_nxt;
            end
        end
    end

endmodule

// File: rtl/e1_rx_frame_ctr.sv
module e1_rx_frame_ctr #(
    parameter int unsigned MF_FRAMES = 16,
    parameter int unsigned FRM_W     = $clog2(MF_FRAMES)
) (
    input  logic clk,
    input  logic rst,
    input  logic mf_start,
    input  logic frame_start,
    input  logic frame_wrap,
    output logic last_frame
);

    localparam logic [FRM_W-1:0] FRM_TOP = FRM_W'(MF_FRAMES - 1);

    logic [FRM_W-1:0] frm_idx;

    assign last_frame = (frm_idx == FRM_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            frm_idx <= '0;
        end else if (mf_start) begin
            frm_idx <= '0;
        end else if (frame_start || frame_wrap) begin
            frm_idx <= last_frame ? '0 : frm_idx + 1'b1;
        end
    end

endmodule

// File: rtl/e1_rx_strobe_dec.sv
module e1_rx_strobe_dec
    import e1_rx_timing_pkg::*;
#(
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              running,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              slot_last_bit,
    input  logic              frame_last_bit,
    input  logic              last_frame,
    input  logic [1:0]        slip_mode,
    input  logic              frac_en,
    input  logic              frac_style,
    input  logic [SLOTS-1:0]  slot_mask,
    input  logic              data_q,
    output logic              ts_clk,
    output logic              fsync,
    output logic              msync,
    output logic              sync_oe,
    output logic              frac_data
);

    strobe_set_t st;
    frac_style_e style;

    assign style = frac_style_e'(frac_style);

    always_comb begin
        st.bypass      = slip_is_bypass(slip_mode);
        st.slot_lsb    = running && slot_last_bit;
        st.frame_end   = running && frame_last_bit && st.bypass;
        st.mf_end      = st.frame_end && last_frame;
        st.slot_chosen = running && frac_en && slot_mask[slot_idx];
    end

    // Slot strobe pin: per-slot LSB strobe, gapped clock or level enable
    always_comb begin
        if (!frac_en) begin
            ts_clk = st.slot_lsb;
        end else begin
            case (style)
                FRAC_GAPPED_CLK: ts_clk = st.slot_chosen && clk;
                default:         ts_clk = st.slot_chosen;
            endcase
        end
    end

    assign fsync     = st.frame_end;
    assign msync     = st.mf_end;
    assign sync_oe   = st.bypass;
    assign frac_data = st.slot_chosen && data_q;

endmodule

// File: rtl/e1_rx_slot_timer.sv
module e1_rx_slot_timer
    import e1_rx_timing_pkg::*;
#(
    parameter int unsigned SLOTS     = DEF_SLOTS,
    parameter int unsigned SLOT_BITS = DEF_SLOT_BITS,
    parameter int unsigned MF_FRAMES = DEF_MF_FRAMES,
    parameter int unsigned SLOT_W    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_mark,
    input  logic              mf_mark,
    input  logic [1:0]        slip_mode,
    input  logic              frac_en,
    input  logic              frac_style,
    input  logic [SLOTS-1:0]  slot_mask,
    input  logic              rx_bit,
    output logic              ts_clk,
    output logic [SLOT_W-1:0] ts_num,
    output logic              fsync,
    output logic              msync,
    output logic              sync_oe,
    output logic              frac_data
);

    localparam int unsigned BIT_W = $clog2(SLOT_BITS);
    localparam int unsigned FRM_W = $clog2(MF_FRAMES);

    logic              running;
    logic [BIT_W-1:0]  bit_idx;
    logic [SLOT_W-1:0] slot_idx;
    logic              slot_last_bit;
    logic              frame_last_bit;
    logic              last_frame;
    logic              any_start;
    logic              data_q;

    assign any_start = frame_mark || mf_mark;

    // Payload bit register, aligned with the counters
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= 1'b0;
        end else begin
            data_q <= rx_bit;
        end
    end

    e1_rx_pos_ctr #(
        .SLOTS     (SLOTS),
        .SLOT_BITS (SLOT_BITS),
        .SLOT_W    (SLOT_W),
        .BIT_W     (BIT_W)
    ) u_pos (
        .clk            (clk),
        .rst            (rst),
        .start          (any_start),
        .running        (running),
        .bit_idx        (bit_idx),
        .slot_idx       (slot_idx),
        .slot_last_bit  (slot_last_bit),
        .frame_last_bit (frame_last_bit)
    );

    e1_rx_frame_ctr #(
        .MF_FRAMES (MF_FRAMES),
        .FRM_W     (FRM_W)
    ) u_frm (
        .clk         (clk),
        .rst         (rst),
        .mf_start    (mf_mark),
        .frame_start (frame_mark),
        .frame_wrap  (running && frame_last_bit),
        .last_frame  (last_frame)
    );

    e1_rx_strobe_dec #(
        .SLOTS  (SLOTS),
        .SLOT_W (SLOT_W)
    ) u_dec (
        .clk            (clk),
        .running        (running),
        .slot_idx       (slot_idx),
        .slot_last_bit  (slot_last_bit),
        .frame_last_bit (frame_last_bit),
        .last_frame     (last_frame),
        .slip_mode      (slip_mode),
        .frac_en        (frac_en),
        .frac_style     (frac_style),
        .slot_mask      (slot_mask),
        .data_q         (data_q),
        .ts_clk         (ts_clk),
        .fsync          (fsync),
        .msync          (msync),
        .sync_oe        (sync_oe),
        .frac_data      (frac_data)
    );

    assign ts_num = slot_idx;

endmodule

// File: rtl/e1_rx_slot_timer_chk.sv
module e1_rx_slot_timer_chk #(
    parameter int unsigned SLOTS  = 32,
    parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_mark,
    input logic              mf_mark,
    input logic              frac_en,
    input logic [SLOTS-1:0]  slot_mask,
    input logic              ts_clk,
    input logic [SLOT_W-1:0] ts_num,
    input logic              fsync,
    input logic              msync,
    input logic              sync_oe,
    input logic              frac_data
);

    localparam logic [SLOT_W-1:0] SLOT_TOP = SLOT_W'(SLOTS - 1);

    // R1
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!fsync && !msync && !frac_data && ts_num == '0));

    // R2
    slot_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ts_clk && !frac_en && !frame_mark && !mf_mark) |=>
        (ts_num == (($past(ts_num) == SLOT_TOP) ? '0 : $past(ts_num) + 1'b1)));

    // R3
    lsb_strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (ts_clk && !frac_en) |=> (!ts_clk || frac_en));

    // R4
    fsync_single_chk: assert property (@(posedge clk) disable iff (rst)
        fsync |=> !fsync);

    // R5
    msync_within_fsync_chk: assert property (@(posedge clk) disable iff (rst)
        msync |-> fsync);

    // R6
    sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_oe |-> (!fsync && !msync));

    // R7
    frac_mask_chk: assert property (@(posedge clk) disable iff (rst)
        frac_data |-> (frac_en && slot_mask[ts_num]));

    // R10
    realign_chk: assert property (@(posedge clk) disable iff (rst)
        frame_mark |=> (ts_num == '0));

endmodule

bind e1_rx_slot_timer e1_rx_slot_timer_chk #(
    .SLOTS  (SLOTS),
    .SLOT_W (SLOT_W)
) u_slot_timer_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_mark (frame_mark),
    .mf_mark    (mf_mark),
    .frac_en    (frac_en),
    .slot_mask  (slot_mask),
    .ts_clk     (ts_clk),
    .ts_num     (ts_num),
    .fsync      (fsync),
    .msync      (msync),
    .sync_oe    (sync_oe),
    .frac_data  (frac_data)
);

// File: tb/test_e1_rx_slot_timer.sv
module test_e1_rx_slot_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_mark = 1'b0;
    logic        mf_mark = 1'b0;
    logic [1:0]  slip_mode = 2'b00;
    logic        frac_en = 1'b0;
    logic        frac_style = 1'b0;
    logic [31:0] slot_mask = '0;
    logic        rx_bit = 1'b0;
    logic        ts_clk;
    logic [4:0]  ts_num;
    logic        fsync;
    logic        msync;
    logic        sync_oe;
    logic        frac_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // Bench model of the position, derived from the requirements
    int m_pos = 0;
    int m_frm = 0;
    bit m_run = 1'b0;
    bit m_data = 1'b0;
    bit m_realign = 1'b0;

    always #10 clk = ~clk;

    e1_rx_slot_timer i_e1_rx_slot_timer (
        .clk        (clk),
        .rst        (rst),
        .frame_mark (frame_mark),
        .mf_mark    (mf_mark),
        .slip_mode  (slip_mode),
        .frac_en    (frac_en),
        .frac_style (frac_style),
        .slot_mask  (slot_mask),
        .rx_bit     (rx_bit),
        .ts_clk     (ts_clk),
        .ts_num     (ts_num),
        .fsync      (fsync),
        .msync      (msync),
        .sync_oe    (sync_oe),
        .frac_data  (frac_data)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_pos <= 0; m_frm <= 0; m_run <= 1'b0; m_data <= 1'b0; m_realign <= 1'b0;
        end else begin
            m_data    <= rx_bit;
            m_realign <= frame_mark && !mf_mark && m_run && (m_pos != 255);
            if (mf_mark) begin
                m_pos <= 0; m_frm <= 0; m_run <= 1'b1;
            end else if (frame_mark) begin
                m_pos <= 0; m_frm <= (m_frm + 1) % 16; m_run <= 1'b1;
            end else if (m_run) begin
                m_pos <= (m_pos + 1) % 256;
                if (m_pos == 255) m_frm <= (m_frm + 1) % 16;
            end
        end
    end

    function automatic bit is_byp(input logic [1:0] s);
        return (s == 2'b00) || (s == 2'b11);
    endfunction

    function automatic bit exp_tsclk(input bit high_phase);
        bit chosen;
        if (!m_run || rst) return 1'b0;
        if (!frac_en) return (m_pos % 8) == 7;
        chosen = slot_mask[m_pos / 8];
        if (!frac_style) return chosen && high_phase;
        return chosen;
    endfunction

    function automatic string tsclk_tag();
        if (!m_run || rst) return "R1";
        if (!frac_en) return "R3";
        return frac_style ? "R9" : "R8";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_high();
        bit live;
        live = m_run && !rst;
        chk(tsclk_tag(), 32'(ts_clk), 32'(exp_tsclk(1'b1)));
        chk(!live ? "R1" : (m_realign ? "R10" : "R2"), 32'(ts_num), live ? 32'(m_pos / 8) : 32'd0);
        chk(!live ? "R1" : "R4", 32'(fsync), 32'(live && is_byp(slip_mode) && m_pos == 255));
        chk(!live ? "R1" : "R5", 32'(msync),
            32'(live && is_byp(slip_mode) && m_pos == 255 && m_frm == 15));
        chk("R6", 32'(sync_oe), 32'(is_byp(slip_mode)));
        chk(!live ? "R1" : "R7", 32'(frac_data),
            32'(live && frac_en && slot_mask[m_pos / 8] && m_data));
    endtask

    task automatic check_low();
        chk(tsclk_tag(), 32'(ts_clk), 32'(exp_tsclk(1'b0)));
    endtask

    // One clock: compare after the rising edge, then drive at the falling edge
    task automatic run_cycle(input bit allow_mark);
        @(posedge clk);
        #5 check_high();
        @(negedge clk);
        rx_bit     = 1'($urandom);
        frame_mark = 1'b0;
        mf_mark    = 1'b0;
        if (allow_mark) begin
            if (m_run && m_pos == 255 && m_frm == 15 && ($urandom % 2) == 0)
                mf_mark = 1'b1;
            else if (m_run && m_pos == 255 && ($urandom % 2) == 0)
                frame_mark = 1'b1;
            else if (($urandom % 500) == 0)
                frame_mark = 1'b1;
        end
        #5 check_low();
    endtask

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'hE1A5_0001);
        // R1: reset state with the most permissive configuration
        frac_en = 1'b1; frac_style = 1'b1; slot_mask = '1; slip_mode = 2'b11;
        repeat (4) run_cycle(1'b0);
        @(negedge clk);
        rst = 1'b0;
        // R1: no marker yet, everything idle
        repeat (40) run_cycle(1'b0);
        // R2/R10: first marker starts slot 0 on the next cycle
        @(negedge clk);
        frame_mark = 1'b1;
        frac_en = 1'b0;
        repeat (300) run_cycle(1'b0);
        // Start a multiframe directly for R5
        @(negedge clk);
        mf_mark = 1'b1;
        for (int seg = 0; seg < 16; seg++) begin
            frac_en    = seg[0];
            frac_style = seg[1];
            slip_mode  = (seg % 3 == 2) ? (seg[2] ? 2'b01 : 2'b10) : (seg[2] ? 2'b11 : 2'b00);
            slot_mask  = (seg == 5) ? 32'h8000_0001 : $urandom;
            repeat (1200) run_cycle(1'b1);
        end
        // R5: long bypass run so a full multiframe ends with msync
        slip_mode = 2'b00; frac_en = 1'b0;
        repeat (4400) run_cycle(1'b0);
        // R1: reset in the middle of traffic
        @(negedge clk);
        rst = 1'b1;
        repeat (3) run_cycle(1'b0);
        @(negedge clk);
        rst = 1'b0;
        repeat (20) run_cycle(1'b0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule